// File: doc/BRIEF.md
# Averaging Add/Subtract Element Unit

This unit forms the halved sum or halved difference of one vector element and one scalar operand, in signed or unsigned form, and rounds the single bit that the halving shifts out according to a 2-bit rounding-mode input. The same scalar operand pairs with each element that the producer streams in, one element per accepted transfer. The arithmetic is done one bit wider than the element, so the intermediate sum or difference never overflows. The halved value therefore always fits the element width, and the unit neither saturates nor flags anything.

The element width is selected per transfer: 8, 16 or the widest supported width (the `ELEN` parameter, default 32). Operands arrive on a valid/ready input and the result leaves on a valid/ready output through a single register stage. The input is accepted whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, the result and its valid are held unchanged and the input is stalled.

Top module: `avg_unit`

## Requirements
- R1: `op` selects the operation: 2'b00 unsigned add, 2'b01 signed add, 2'b10 unsigned subtract, 2'b11 signed subtract (bit 1 = subtract, bit 0 = signed). Both operands are widened by one bit before the operation: zero-extended for unsigned and sign-extended for signed. The add or subtract is done at that width, wrapping modulo 2^(EW+1).
- R2: The wide result is shifted right by one. Its bits EW..1 form the kept value, and bit 0 is the discarded bit.
- R3: `rnd` adds an increment to the kept value. 2'b00 (nearest, ties up) adds the discarded bit. 2'b01 (nearest, ties even) adds the discarded bit only when the kept LSB is 1. 2'b10 (truncate) adds nothing. 2'b11 (jam to odd) adds the discarded bit only when the kept LSB is 0.
- R4: `ew_sel` picks the element width EW: 2'd0 = 8, 2'd1 = 16, 2'd2 = 32, and any code beyond the widest lane selects the widest lane (ELEN). Operand bits above EW are ignored, and result bits above EW are zero.
- R5: The rounded result wraps to EW bits. There is no saturation: signed 8-bit 0x80 minus 0x7F in mode 2'b00 gives 0x81.
- R6: A transfer accepted on a rising edge (in_valid and in_ready high) appears on out_data with out_valid high right after that edge.
- R7: While out_valid is high and out_ready is low, in_ready is low and out_valid and out_data stay unchanged.
- R8: After reset, out_valid is low and in_ready is high.
- R9: When out_ready is high and no new transfer is accepted, out_valid goes low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Unit accepts operands this cycle |
| elem | input | ELEN | Vector element operand |
| scalar | input | ELEN | Scalar operand |
| op | input | 2 | Operation select (R1) |
| rnd | input | 2 | Rounding mode (R3) |
| ew_sel | input | 2 | Element width code (R4) |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ELEN | Rounded averaged result, zero above EW |

## Verification
The bench aims at halving results whose discarded bit is 1, under each rounding mode. A design that mixed up the tie rules would be off by one there, in the kept LSB. It also drives operands at the signed and unsigned extremes. A design that widened with the wrong kind of extension, or that saturated, would return a wrong sign or a clamped value on those. Narrow widths are given garbage in the upper operand bits, which exposes any lane leaking bits above EW. A stall with a new operand waiting shows whether a held result gets overwritten.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic [1:0] {
    OP_ADDU = 2'b00,
    OP_ADDS = 2'b01,
    OP_SUBU = 2'b10,
    OP_SUBS = 2'b11
  } avg_op_e;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'b00,
    RND_NEAR_EVEN = 2'b01,
    RND_TRUNC     = 2'b10,
    RND_JAM_ODD   = 2'b11
  } avg_rnd_e;

  localparam int EW_SEL_W = 2;
  localparam int MIN_EW   = 8;
endpackage

// File: rtl/avg_round.sv
module avg_round
  import avg_pkg::*;
(
  input  logic [1:0] rnd,
  input  logic       kept_lsb,
  input  logic       dropped,
  output logic       incr
);
  always_comb begin
    unique case (avg_rnd_e'(rnd))
      RND_NEAR_UP:   incr = dropped;
      RND_NEAR_EVEN: incr = dropped & kept_lsb;
      RND_TRUNC:     incr = 1'b0;
      RND_JAM_ODD:   incr = dropped & ~kept_lsb;
      default:       incr = 1'b0;
    endcase
  end
endmodule

// File: rtl/avg_lane.sv
module avg_lane #(
  parameter int EW = 8
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [1:0]    op,
  input  logic [1:0]    rnd,
  output logic [EW-1:0] res
);
  logic          is_sub, is_signed;
  logic [EW:0]   a_wide, b_wide, wide;
  logic [EW-1:0] kept;
  logic          dropped, incr;

  assign is_sub    = op[1];
  assign is_signed = op[0];
  assign a_wide    = {is_signed & a[EW-1], a};
  assign b_wide    = {is_signed & b[EW-1], b};
  assign wide      = is_sub ? (a_wide - b_wide) : (a_wide + b_wide);
  assign kept      = wide[EW:1];
  assign dropped   = wide[0];

  avg_round u_round (
    .rnd      (rnd),
    .kept_lsb (kept[0]),
    .dropped  (dropped),
    .incr     (incr)
  );

  assign res = kept + {{(EW-1){1'b0}}, incr};
endmodule

// File: rtl/avg_unit.sv
module avg_unit
  import avg_pkg::*;
#(
  parameter int ELEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ELEN-1:0] elem,
  input  logic [ELEN-1:0] scalar,
  input  logic [1:0]      op,
  input  logic [1:0]      rnd,
  input  logic [1:0]      ew_sel,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ELEN-1:0] out_data
);
  localparam int NLANE = $clog2(ELEN / MIN_EW) + 1;
  localparam int NSLOT = 1 << EW_SEL_W;

  logic [ELEN-1:0]     lane_res [NSLOT];
  logic [EW_SEL_W-1:0] sel;
  logic                accept;

  for (genvar g = 0; g < NSLOT; g++) begin : g_lane
    if (g < NLANE) begin : g_on
      localparam int EW = MIN_EW << g;
      logic [EW-1:0] r;
      avg_lane #(.EW(EW)) u_lane (
        .a   (elem[EW-1:0]),
        .b   (scalar[EW-1:0]),
        .op  (op),
        .rnd (rnd),
        .res (r)
      );
      assign lane_res[g] = ELEN'(r);
    end else begin : g_off
      assign lane_res[g] = '0;
    end
  end

  always_comb begin
    if (int'(ew_sel) >= NLANE) sel = EW_SEL_W'(NLANE - 1);
    else                       sel = ew_sel;
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept)   out_data  <= lane_res[sel];
    end
  end
endmodule

// File: rtl/avg_unit_checker.sv
module avg_unit_checker #(
  parameter int ELEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      ew_sel,
  input logic            out_valid,
  input logic            out_ready,
  input logic [ELEN-1:0] out_data
);
  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_narrow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ew_sel == 2'd0 |=> out_data[ELEN-1:8] == '0);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !in_valid |=> !out_valid);
endmodule

bind avg_unit avg_unit_checker #(.ELEN(ELEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ew_sel(ew_sel), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/avg_unit_tb.sv
module avg_unit_tb;
  localparam int ELEN = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [ELEN-1:0] elem = 0, scalar = 0, out_data;
  logic [1:0] op = 0, rnd = 0, ew_sel = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  avg_unit #(.ELEN(ELEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .elem(elem), .scalar(scalar), .op(op), .rnd(rnd), .ew_sel(ew_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int width_of(input logic [1:0] code);
    if (code == 2'd0) return 8;
    if (code == 2'd1) return 16;
    return 32;
  endfunction

  function automatic logic [31:0] model(input logic [1:0] o, input logic [1:0] m,
                                        input logic [1:0] code,
                                        input logic [31:0] a, input logic [31:0] b);
    int w = width_of(code);
    longint ma = (longint'(1) << w) - 1;
    longint mw = (longint'(1) << (w + 1)) - 1;
    longint ea = longint'(a) & ma;
    longint eb = longint'(b) & ma;
    longint s, kept, res;
    logic d, lsb, inc;
    if (o[0]) begin
      if (ea[w-1]) ea = ea - (longint'(1) << w);
      if (eb[w-1]) eb = eb - (longint'(1) << w);
    end
    s = o[1] ? ea - eb : ea + eb;
    s = s & mw;
    kept = (s >> 1) & ma;
    d = s[0];
    lsb = kept[0];
    case (m)
      2'd0: inc = d;
      2'd1: inc = d & lsb;
      2'd2: inc = 1'b0;
      default: inc = d & !lsb;
    endcase
    res = (kept + longint'(inc)) & ma;
    return res[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_one(input string req, input logic [1:0] o, input logic [1:0] m,
                          input logic [1:0] code, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o; rnd = m; ew_sel = code; elem = a; scalar = b;
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check(req, out_data, model(o, m, code, a, b));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    #1;
    check("R8 out_valid", 32'(out_valid), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 in_ready", 32'(in_ready), 32'd1);
    check("R8 out_valid after", 32'(out_valid), 32'd0);

    // R3 rounding modes on a halving that drops a 1 (kept LSB 0 and 1)
    send_one("R3 up lsb0", 2'b00, 2'b00, 2'd0, 32'd1, 32'd0);
    check("R3 up lsb0 value", out_data, 32'd1);
    send_one("R3 even lsb0", 2'b00, 2'b01, 2'd0, 32'd1, 32'd0);
    check("R3 even lsb0 value", out_data, 32'd0);
    send_one("R3 down", 2'b00, 2'b10, 2'd0, 32'd3, 32'd0);
    check("R3 down value", out_data, 32'd1);
    send_one("R3 odd lsb0", 2'b00, 2'b11, 2'd0, 32'd1, 32'd0);
    check("R3 odd lsb0 value", out_data, 32'd1);
    send_one("R3 even lsb1", 2'b00, 2'b01, 2'd0, 32'd3, 32'd0);
    check("R3 even lsb1 value", out_data, 32'd2);
    send_one("R3 odd lsb1", 2'b00, 2'b11, 2'd0, 32'd3, 32'd0);
    check("R3 odd lsb1 value", out_data, 32'd1);

    // R1 and R2 extremes
    send_one("R1 unsigned add max", 2'b00, 2'b00, 2'd0, 32'hFF, 32'hFF);
    check("R1 unsigned add max value", out_data, 32'hFF);
    send_one("R1 signed add neg", 2'b01, 2'b10, 2'd0, 32'h80, 32'h80);
    check("R1 signed add neg value", out_data, 32'h80);
    send_one("R2 unsigned sub borrow", 2'b10, 2'b10, 2'd1, 32'd0, 32'd1);
    check("R2 unsigned sub borrow value", out_data, 32'hFFFF);

    // R5 no saturation
    send_one("R5 signed sub", 2'b11, 2'b00, 2'd0, 32'h80, 32'h7F);
    check("R5 signed sub value", out_data, 32'h81);

    // R4 upper bits ignored, wide code maps to widest
    send_one("R4 upper ignored", 2'b01, 2'b00, 2'd0, 32'hABCD_EF01, 32'h1234_5603);
    check("R4 upper ignored value", out_data, 32'h02);
    send_one("R4 code3", 2'b11, 2'b11, 2'd3, 32'h8000_0000, 32'h0000_0001);
    check("R4 code3 value", out_data, model(2'b11, 2'b11, 2'd2, 32'h8000_0000, 32'h1));

    // R9 drain
    @(negedge clk);
    check("R9 drain", 32'(out_valid), 32'd0);

    // R6 / R7 back-pressure with a second operand waiting
    @(negedge clk);
    op = 2'b00; rnd = 2'b00; ew_sel = 2'd1; elem = 32'd100; scalar = 32'd50;
    in_valid = 1; out_ready = 0;
    @(negedge clk);
    check("R6 valid after accept", 32'(out_valid), 32'd1);
    check("R6 value", out_data, 32'd75);
    held = out_data;
    elem = 32'd10; scalar = 32'd20;
    check("R7 in_ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    check("R7 held data", out_data, held);
    check("R7 held valid", 32'(out_valid), 32'd1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R7 next value", out_data, 32'd15);
    @(negedge clk);

    // random mix
    for (int i = 0; i < 400; i++) begin
      send_one("R1 R3 R4 random", 2'($urandom), 2'($urandom), 2'($urandom), $urandom, $urandom);
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule